// File: doc/BRIEF.md
# Truncated Low-Frequency 2D DCT Engine

This block computes an approximate two-dimensional discrete cosine transform of an 8x8 tile of 8-bit grayscale samples. Only the low-frequency corner is evaluated. High-frequency terms are never formed, so their arithmetic and storage are never built. Pixels enter one per accepted handshake in raster order, row after row. Each pixel is level-shifted by subtracting the mid-scale value 128. A horizontal pass forms the five lowest horizontal frequencies of each row. These are kept at full precision as signed two's-complement values in a 5-wide by 8-deep transpose store. Once all eight rows are stored, a vertical pass takes that store and produces the 20 retained coefficients.

Cosine constants are signed fixed-point values with 10 fractional bits, held in a 12-bit field by default. Each result is rounded to the nearest integer and presented as a 12-bit two's-complement coefficient. The 20 coefficients of a tile leave in zig-zag order, one every eight cycles, and the last of them is flagged. The block holds a single tile, so it accepts no new pixels while the vertical pass runs.

Top module: `dct_trunc_top`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid` and `out_last` are 0. No coefficient is presented before a full tile of 64 pixels has been accepted.
- R2: Each output equals the orthonormal 8x8 DCT-II of (pixel - 128), X(u,v) = 1/4 c(u) c(v) sum over i,j of s(i,j) cos((2i+1)u pi/16) cos((2j+1)v pi/16), with c(0)=1/sqrt(2) and c(k)=1 otherwise. Here i is the pixel row, j the pixel column, u the vertical frequency and v the horizontal frequency. The value is rounded and given as a 12-bit signed integer, within 1 LSB of the ideal rounded value.
- R3: Per tile exactly 20 coefficients are output, in this (u,v) order: (0,0) (0,1) (1,0) (2,0) (1,1) (0,2) (0,3) (1,2) (2,1) (3,0) (4,0) (3,1) (2,2) (1,3) (0,4) (1,4) (2,3) (3,2) (4,1) (4,2). This is the zig-zag scan restricted to u<5 and v<5.
- R4: `in_ready` is 0 from the cycle after the 64th pixel of a tile is accepted until the cycle in which that tile's 20th coefficient is presented. In that cycle it returns to 1. Pixels offered on `in_valid` while `in_ready` is 0 have no effect on any output.
- R5: `out_last` is 1 together with the 20th coefficient of each tile and 0 with the other 19.
- R6: The first coefficient of a tile is valid 8 cycles after the clock edge that accepts the tile's 64th pixel. Each following coefficient comes exactly 8 cycles after the previous one. `out_valid` is a one-cycle pulse.
- R7: Idle cycles with `in_valid` at 0 between pixels do not change any output value. Only accepted pixels advance the raster position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | 8 | Unsigned grayscale sample, raster order |
| out_valid | output | 1 | Coefficient present this cycle |
| out_coef | output | 12 | Signed coefficient |
| out_last | output | 1 | Marks the final coefficient of a tile |

## Verification
Flat tiles at mid-scale, black and white pin the DC path and check that every AC term comes out as zero. Horizontal and vertical ramps put energy in only one frequency axis, so a swapped index or a wrong scan position shows up at once. A low-amplitude checkerboard and pseudo-random tiles drive both signs through the transpose store and test the signed arithmetic. One random tile is fed with idle gaps, and another is preceded by junk pixels held valid during the vertical pass. Together these show that stalls and ignored offers leave the results unchanged.

// File: rtl/dct_trunc_pkg.sv
package dct_trunc_pkg;

   // tile edge; the constant table below is written for this size only
   localparam int BLK = 8;

   // magnitude of 0.5*cos(m*pi/16) scaled by 2^10, m = 0..7
   function automatic int cos_mag(input int m);
      case (m)
         0: return 512;
         1: return 502;
         2: return 473;
         3: return 426;
         4: return 362;
         5: return 284;
         6: return 196;
         default: return 100;
      endcase
   endfunction

   // scaled basis weight for frequency k at sample position n
   function automatic int basis(input int k, input int n);
      int m;
      if (k == 0) return 362;
      m = ((2 * n + 1) * k) % 32;
      if (m < 8)                 return cos_mag(m);
      else if (m == 8 || m == 24) return 0;
      else if (m <= 16)          return -cos_mag(16 - m);
      else if (m < 24)           return -cos_mag(m - 16);
      else                       return cos_mag(32 - m);
   endfunction

   // position idx of the zig-zag scan restricted to a lim x lim corner
   function automatic int zz_pos(input int idx, input int lim, input bit want_col);
      int cnt;
      int r;
      int c;
      cnt = 0;
      for (int d = 0; d < 2 * BLK - 1; d++) begin
         for (int s = 0; s <= d; s++) begin
            r = (d % 2 == 1) ? s : d - s;
            c = d - r;
            if (r < lim && c < lim) begin
               if (cnt == idx) return want_col ? c : r;
               cnt++;
            end
         end
      end
      return 0;
   endfunction

endpackage

// File: rtl/dct_row_pass.sv
module dct_row_pass
   import dct_trunc_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 12,
   parameter int KEEP   = 5,
   parameter int MID_W  = 23
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [PIX_W-1:0]        pix,
   output logic                    wr_en,
   output logic [$clog2(BLK)-1:0]  wr_row,
   output logic [KEEP*MID_W-1:0]   wr_data,
   output logic                    block_done
);
   localparam int BW = $clog2(BLK);

   logic [BW-1:0] col_q;
   logic [BW-1:0] row_q;
   logic signed [PIX_W-1:0]  smp;
   logic signed [COEF_W-1:0] ctab [KEEP][BLK];

   // level shift by half scale: flip the top bit
   assign smp = {~pix[PIX_W-1], pix[PIX_W-2:0]};

   for (genvar k = 0; k < KEEP; k++) begin : g_freq
      for (genvar j = 0; j < BLK; j++) begin : g_tap
         assign ctab[k][j] = COEF_W'(basis(k, j));
      end

      logic signed [MID_W-1:0] prod;
      logic signed [MID_W-1:0] base;
      logic signed [MID_W-1:0] acc_q;
      logic signed [MID_W-1:0] sum_nx;

      assign prod = smp * ctab[k][col_q];

      always_comb begin
         if (col_q == '0) base = '0;
         else             base = acc_q;
      end

      assign sum_nx = base + prod;
      assign wr_data[k*MID_W +: MID_W] = sum_nx;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    acc_q <= '0;
         else if (take) acc_q <= sum_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (take) begin
         col_q <= col_q + 1'b1;
         if (col_q == BW'(BLK - 1)) row_q <= row_q + 1'b1;
      end
   end

   assign wr_en      = take && (col_q == BW'(BLK - 1));
   assign wr_row     = row_q;
   assign block_done = wr_en && (row_q == BW'(BLK - 1));

endmodule

// File: rtl/dct_xpose_buf.sv
module dct_xpose_buf
   import dct_trunc_pkg::*;
#(
   parameter int KEEP  = 5,
   parameter int MID_W = 23
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [$clog2(BLK)-1:0]      wr_row,
   input  logic [KEEP*MID_W-1:0]       wr_data,
   input  logic [$clog2(BLK)-1:0]      rd_row,
   input  logic [$clog2(KEEP)-1:0]     rd_col,
   output logic signed [MID_W-1:0]     rd_data
);
   logic signed [MID_W-1:0] mem [BLK][KEEP];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int k = 0; k < KEEP; k++) begin
            mem[wr_row][k] <= wr_data[k*MID_W +: MID_W];
         end
      end
   end

   assign rd_data = mem[rd_row][rd_col];

endmodule

// File: rtl/dct_col_pass.sv
module dct_col_pass
   import dct_trunc_pkg::*;
#(
   parameter int COEF_W  = 12,
   parameter int KEEP    = 5,
   parameter int MID_W   = 23,
   parameter int NUM_OUT = 20,
   parameter int FRAC    = 10,
   parameter int OUT_W   = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   output logic                        busy,
   output logic [$clog2(BLK)-1:0]      rd_row,
   output logic [$clog2(KEEP)-1:0]     rd_col,
   input  logic signed [MID_W-1:0]     rd_data,
   output logic                        out_valid,
   output logic signed [OUT_W-1:0]     out_data,
   output logic                        out_last
);
   localparam int BW    = $clog2(BLK);
   localparam int KW    = $clog2(KEEP);
   localparam int IW    = $clog2(NUM_OUT);
   localparam int ACC_W = MID_W + COEF_W + BW;
   localparam int SHIFT = 2 * FRAC;
   localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) << (SHIFT - 1);
   localparam logic signed [ACC_W-1:0] OMAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] OMIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic [KW-1:0]            u_tab [NUM_OUT];
   logic [KW-1:0]            v_tab [NUM_OUT];
   logic signed [COEF_W-1:0] ctab  [KEEP][BLK];

   for (genvar n = 0; n < NUM_OUT; n++) begin : g_scan
      assign u_tab[n] = KW'(zz_pos(n, KEEP, 1'b0));
      assign v_tab[n] = KW'(zz_pos(n, KEEP, 1'b1));
   end
   for (genvar k = 0; k < KEEP; k++) begin : g_freq
      for (genvar i = 0; i < BLK; i++) begin : g_tap
         assign ctab[k][i] = COEF_W'(basis(k, i));
      end
   end

   logic [IW-1:0]            idx_q;
   logic [BW-1:0]            tap_q;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  base;
   logic signed [ACC_W-1:0]  prod;
   logic signed [ACC_W-1:0]  total;
   logic signed [ACC_W-1:0]  rnd_full;
   logic signed [OUT_W-1:0]  res;

   assign rd_row = tap_q;
   assign rd_col = v_tab[idx_q];
   assign prod   = ctab[u_tab[idx_q]][tap_q] * rd_data;

   always_comb begin
      if (tap_q == '0) base = '0;
      else             base = acc_q;
   end

   assign total    = base + prod;
   assign rnd_full = (total + RND) >>> SHIFT;

   if (ACC_W - SHIFT > OUT_W) begin : g_sat
      always_comb begin
         if (rnd_full > OMAX)      res = OMAX[OUT_W-1:0];
         else if (rnd_full < OMIN) res = OMIN[OUT_W-1:0];
         else                      res = rnd_full[OUT_W-1:0];
      end
   end else begin : g_wrap
      assign res = rnd_full[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx_q     <= '0;
         tap_q     <= '0;
         acc_q     <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            idx_q <= '0;
            tap_q <= '0;
         end else if (busy) begin
            acc_q <= total;
            if (tap_q == BW'(BLK - 1)) begin
               tap_q     <= '0;
               out_valid <= 1'b1;
               out_data  <= res;
               out_last  <= (idx_q == IW'(NUM_OUT - 1));
               if (idx_q == IW'(NUM_OUT - 1)) begin
                  busy  <= 1'b0;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end else begin
               tap_q <= tap_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dct_trunc_top.sv
module dct_trunc_top
   import dct_trunc_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int COEF_W  = 12,
   parameter int FRAC    = 10,
   parameter int KEEP    = 5,
   parameter int NUM_OUT = 20,
   parameter int OUT_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [PIX_W-1:0]        in_pixel,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_coef,
   output logic                    out_last
);
   localparam int BW    = $clog2(BLK);
   localparam int KW    = $clog2(KEEP);
   localparam int MID_W = PIX_W + COEF_W + BW;

   if (FRAC != 10) begin : g_chk_frac
      $error("constant table assumes 10 fractional bits");
   end
   if (COEF_W < 11) begin : g_chk_coef
      $error("constant field too narrow");
   end
   if (KEEP < 2 || KEEP > BLK) begin : g_chk_keep
      $error("retained frequency count out of range");
   end
   if (NUM_OUT < 1 || NUM_OUT > KEEP * KEEP) begin : g_chk_nout
      $error("retained coefficient count out of range");
   end
   if (PIX_W < 2) begin : g_chk_pix
      $error("pixel width too small");
   end

   logic                  take;
   logic                  col_busy;
   logic                  wr_en;
   logic [BW-1:0]         wr_row;
   logic [KEEP*MID_W-1:0] wr_data;
   logic                  block_done;
   logic [BW-1:0]         rd_row;
   logic [KW-1:0]         rd_col;
   logic signed [MID_W-1:0] rd_data;

   assign in_ready = ~col_busy;
   assign take     = in_valid && in_ready;

   dct_row_pass #(
      .PIX_W (PIX_W),
      .COEF_W(COEF_W),
      .KEEP  (KEEP),
      .MID_W (MID_W)
   ) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .pix       (in_pixel),
      .wr_en     (wr_en),
      .wr_row    (wr_row),
      .wr_data   (wr_data),
      .block_done(block_done)
   );

   dct_xpose_buf #(
      .KEEP (KEEP),
      .MID_W(MID_W)
   ) u_buf (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_row (wr_row),
      .wr_data(wr_data),
      .rd_row (rd_row),
      .rd_col (rd_col),
      .rd_data(rd_data)
   );

   dct_col_pass #(
      .COEF_W (COEF_W),
      .KEEP   (KEEP),
      .MID_W  (MID_W),
      .NUM_OUT(NUM_OUT),
      .FRAC   (FRAC),
      .OUT_W  (OUT_W)
   ) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (block_done),
      .busy     (col_busy),
      .rd_row   (rd_row),
      .rd_col   (rd_col),
      .rd_data  (rd_data),
      .out_valid(out_valid),
      .out_data (out_coef),
      .out_last (out_last)
   );

endmodule

// File: rtl/dct_trunc_chk.sv
module dct_trunc_chk #(
   parameter int NUM_OUT = 20
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_last
);
   localparam int OCW = $clog2(NUM_OUT);

   logic [5:0]     pix_cnt;
   logic           pend;
   logic [2:0]     sp;
   logic [OCW-1:0] out_cnt;
   logic           take;

   assign take = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_cnt <= '0;
         pend    <= 1'b0;
         sp      <= '0;
         out_cnt <= '0;
      end else begin
         if (take) pix_cnt <= pix_cnt + 1'b1;
         if (take && pix_cnt == '1) begin
            pend <= 1'b1;
            sp   <= '0;
         end else if (out_valid && out_last) begin
            pend <= 1'b0;
         end else if (pend) begin
            sp <= sp + 1'b1;
         end
         if (out_valid) out_cnt <= (out_cnt == OCW'(NUM_OUT - 1)) ? '0 : out_cnt + 1'b1;
      end
   end

   // R1: nothing comes out while no full tile is pending
   a_r1_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> (!out_valid && !out_last));

   // R4: intake closed while a tile is in the vertical pass
   a_r4_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !(out_valid && out_last)) |-> !in_ready);

   // R4: intake open whenever no tile is pending
   a_r4_ready_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> in_ready);

   // R5: last flag exactly on the final coefficient
   a_r5_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (out_cnt == OCW'(NUM_OUT - 1))));

   // R6: coefficients land on the eight-cycle grid after the tile closes
   a_r6_cadence: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pend && sp == 3'd0));

   // R6: one-cycle valid pulses
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

bind dct_trunc_top dct_trunc_chk #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_last (out_last)
);

// File: tb/dct_trunc_top_bench.sv
module dct_trunc_top_bench;
   localparam int  CLK_PERIOD = 10;
   localparam int  NOUT       = 20;
   localparam real PI         = 3.14159265358979;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_pixel = '0;
   logic              in_ready;
   logic              out_valid;
   logic signed [11:0] out_coef;
   logic              out_last;

   dct_trunc_top u_dct_trunc_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_pixel (in_pixel),
      .out_valid(out_valid),
      .out_coef (out_coef),
      .out_last (out_last)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    checks = 0;
   int    fails  = 0;
   int    exp_q[$];
   string tag_q[$];
   int    blk[64];
   int    last_acc = 0;
   int    nblk = 0;
   int    m_e;
   int    m_d;
   string m_t;
   logic [31:0] seed = 32'h1234_5678;
   bit    timeout = 1'b0;

   // scan order of the retained positions (vertical, horizontal)
   int zu[NOUT] = '{0,0,1,2,1,0,0,1,2,3,4,3,2,1,0,1,2,3,4,4};
   int zv[NOUT] = '{0,1,0,0,1,2,3,2,1,0,0,1,2,3,4,4,3,2,1,2};

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int ideal(input int u, input int v);
      real s;
      real x;
      real cu;
      real cv;
      s = 0.0;
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            s += (real'(blk[i*8+j]) - 128.0)
                 * $cos(real'((2*i+1)*u) * PI / 16.0)
                 * $cos(real'((2*j+1)*v) * PI / 16.0);
         end
      end
      cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
      cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
      x  = 0.25 * cu * cv * s;
      if (x >= 0.0) return $rtoi(x + 0.5);
      else          return -$rtoi(0.5 - x);
   endfunction

   function automatic int rnd8();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed[23:16]);
   endfunction

   // driver: queue expectations, then feed the tile; stall>0 inserts gaps (R7)
   task automatic send_block(input string tag, input int stall);
      int ae;
      ae = 0;
      for (int n = 0; n < NOUT; n++) begin
         exp_q.push_back(ideal(zu[n], zv[n]));
         tag_q.push_back(tag);
      end
      for (int p = 0; p < 64; p++) begin
         if (stall != 0 && (p % stall) == 1) begin
            in_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_pixel = 8'(blk[p]);
         while (!in_ready) @(negedge clk);
         ae = cyc + 1;
         @(negedge clk);
      end
      last_acc = ae;
      // R4: intake must be closed right after the tile is complete
      check(in_ready == 1'b0, "R4", "in_ready after 64th pixel", int'(in_ready), 0);
      // junk offered while busy must be ignored (R4)
      in_valid = 1'b1;
      in_pixel = 8'hA5;
   endtask

   // monitor: pop and compare as results appear
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "coefficient with nothing queued", int'(out_coef), 0);
         end else begin
            m_e = exp_q.pop_front();
            m_t = tag_q.pop_front();
            m_d = int'(out_coef) - m_e;
            if (m_d < 0) m_d = -m_d;
            check(m_d <= 1, m_t, $sformatf("coef %0d value", nblk), int'(out_coef), m_e);
            check(out_last == (nblk == NOUT - 1), "R5", $sformatf("last flag at %0d", nblk),
                  int'(out_last), int'(nblk == NOUT - 1));
            check(cyc == last_acc + 8 * (nblk + 1), "R6", $sformatf("cycle of coef %0d", nblk),
                  cyc, last_acc + 8 * (nblk + 1));
            if (nblk == NOUT - 1)
               check(in_ready == 1'b1, "R4", "in_ready with final coef", int'(in_ready), 1);
            nblk = (nblk == NOUT - 1) ? 0 : nblk + 1;
         end
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1: reset state
            check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
            check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
            check(out_last == 1'b0, "R1", "out_last after reset", int'(out_last), 0);

            for (int p = 0; p < 64; p++) blk[p] = 128;
            send_block("R2", 0);
            for (int p = 0; p < 64; p++) blk[p] = 0;
            send_block("R2", 0);
            for (int p = 0; p < 64; p++) blk[p] = 255;
            send_block("R2", 0);
            for (int p = 0; p < 64; p++) blk[p] = 16 + 30 * (p % 8);
            send_block("R3", 0);
            for (int p = 0; p < 64; p++) blk[p] = 16 + 30 * (p / 8);
            send_block("R3", 0);
            for (int p = 0; p < 64; p++) blk[p] = (((p / 8) + (p % 8)) % 2 == 0) ? 64 : 192;
            send_block("R2", 0);
            for (int p = 0; p < 64; p++) blk[p] = rnd8();
            send_block("R2", 0);
            for (int p = 0; p < 64; p++) blk[p] = rnd8();
            send_block("R7", 3);
            for (int p = 0; p < 64; p++) blk[p] = rnd8();
            send_block("R4", 0);
            in_valid = 1'b0;
            wait (exp_q.size() == 0);
            repeat (12) @(negedge clk);
            // R1: no output once idle
            check(out_valid == 1'b0, "R1", "out_valid when idle", int'(out_valid), 0);
            check(exp_q.size() == 0, "R3", "coefficients left over", exp_q.size(), 0);
         end
         begin
            repeat (100000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) check(1'b0, "R6", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule